// File: doc/BRIEF.md
# Masked Simultaneous-Sample Converter Slice

This block models one eight-input converter slice. A channel-enable mask sits in a configuration register. A single start pulse freezes every input sample in the same clock edge. The slice then releases the conversions of the enabled channels one at a time on a cycle-counted schedule. Disabled channels take no slot, so a smaller mask gives a shorter sequence.

Results come out through one data port that the host reads over and over. Each read strobe steps to the next enabled channel, lowest channel number first. Two sticky flags report progress. One rises when the first enabled result is ready. The other rises when the last enabled result is ready. Timing is set in clock cycles by two parameters: the latency to the first result and the spacing of each further result.

Top module: `cvs_slice`

## Requirements
- R1: A configuration write loads bit i of the 16-bit word (for i from 0 to 7) as the enable of channel i, where 1 means enabled. Bits 15..8 have no effect.
- R2: After reset all eight channels are enabled, both flags are low and the data port reads FFFFh.
- R3: A start pulse captures all eight inputs on the same clock edge. Input changes after that edge do not alter the results of that run.
- R4: Each read strobe returns exactly one result per enabled channel. The results come in ascending channel order, and disabled channels are skipped.
- R5: Every data word carries the 12-bit result in bits 11..0 with the LSB at bit 0. Bits 15..12 are always 1.
- R6: With n channels enabled (n > 0), the k-th result becomes readable FIRST_LAT + (k-1)*SLOT_LAT cycles after the start edge. The first-ready flag rises with result 1 and the last-ready flag rises with result n. Both flags stay high until the next start.
- R7: Each disabled channel shortens the time from start to the last-ready flag by SLOT_LAT cycles.
- R8: A start pulse rewinds the read position to the first enabled channel. When the mask is nonzero, it also clears both flags in the next cycle.
- R9: The data port reads FFFFh and a read strobe does not advance while the next result is not yet converted. The same holds once every enabled result has been read.
- R10: With an all-zero mask, a start pulse sets both flags in the next cycle and the port produces only FFFFh.
- R11: The mask used by a run is the mask held when its start pulse arrives. A configuration write during the run takes effect at the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word; bits 7..0 are the channel enables |
| start | input | 1 | One-cycle start pulse |
| rd_en | input | 1 | Read strobe; steps to the next result |
| smp_in | input | 96 | Eight 12-bit samples; channel i in bits 12*i+11..12*i |
| rd_data | output | 16 | Current result word, or FFFFh when none is available |
| first_rdy | output | 1 | First enabled result converted |
| last_rdy | output | 1 | Last enabled result converted |

## Verification
The assertions assume a start pulse lasts one cycle. They also assume that a read strobe and a start pulse in the same cycle resolve in favour of the start. The stimulus drives every strobe for a single cycle on the falling edge. It does issue reads before results are ready and after they run out, and it restarts in the middle of a readout. It also writes the mask during a run, so that the capture-at-start rule is exercised and not avoided.

// File: rtl/cvs_pkg.sv
package cvs_pkg;
    localparam int unsigned CVS_NCH = 8;
    localparam int unsigned CVS_DW  = 12;
    localparam int unsigned CVS_WW  = 16;

    // Pacing state for the conversion sequence
    typedef struct packed {
        logic       busy;
        logic [7:0] tmr;
    } pace_t;

    // Places a result into a bus word with the unused upper bits set
    function automatic logic [CVS_WW-1:0] fill_word(input logic [CVS_DW-1:0] v);
        logic [CVS_WW-1:0] w;
        w = '1;
        w[CVS_DW-1:0] = v;
        return w;
    endfunction
endpackage

// File: rtl/cvs_capture.sv
module cvs_capture #(
    parameter int unsigned NCH = 8,
    parameter int unsigned DW  = 12,
    localparam int unsigned CW = $clog2(NCH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [NCH-1:0]    cfg_mask,
    input  logic              start,
    input  logic [NCH*DW-1:0] smp_in,
    output logic [NCH-1:0]    mask_q,
    output logic [NCH-1:0]    cap_mask,
    output logic [NCH*DW-1:0] snap,
    output logic [CW-1:0]     n_en
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q   <= '1;
            cap_mask <= '0;
        end else begin
            if (cfg_we) mask_q   <= cfg_mask;
            if (start)  cap_mask <= mask_q;
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_hold
        always_ff @(posedge clk) begin
            if (rst)        snap[i*DW +: DW] <= '0;
            else if (start) snap[i*DW +: DW] <= smp_in[i*DW +: DW];
        end
    end

    assign n_en = CW'($countones(cap_mask));
endmodule

// File: rtl/cvs_pacer.sv
module cvs_pacer
    import cvs_pkg::*;
#(
    parameter int unsigned CW        = 4,
    parameter int unsigned FIRST_LAT = 4,
    parameter int unsigned SLOT_LAT  = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          mask_nz,
    input  logic [CW-1:0] n_en,
    output logic [CW-1:0] dcnt,
    output logic          first_q,
    output logic          last_q
);
    pace_t       st;
    logic [7:0]  lim;

    assign lim = (dcnt == '0) ? 8'(FIRST_LAT - 1) : 8'(SLOT_LAT - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= '0;
            dcnt    <= '0;
            first_q <= 1'b0;
            last_q  <= 1'b0;
        end else if (start) begin
            st.busy <= mask_nz;
            st.tmr  <= '0;
            dcnt    <= '0;
            first_q <= ~mask_nz;
            last_q  <= ~mask_nz;
        end else if (st.busy) begin
            if (st.tmr == lim) begin
                st.tmr  <= '0;
                dcnt    <= dcnt + 1'b1;
                first_q <= 1'b1;
                if (dcnt + 1'b1 == n_en) begin
                    st.busy <= 1'b0;
                    last_q  <= 1'b1;
                end
            end else begin
                st.tmr <= st.tmr + 8'd1;
            end
        end
    end
endmodule

// File: rtl/cvs_reader.sv
module cvs_reader
    import cvs_pkg::*;
#(
    parameter int unsigned NCH = 8,
    parameter int unsigned DW  = 12,
    parameter int unsigned WW  = 16,
    localparam int unsigned CW = $clog2(NCH + 1),
    localparam int unsigned SW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              rd_en,
    input  logic [NCH-1:0]    cap_mask,
    input  logic [NCH*DW-1:0] snap,
    input  logic [CW-1:0]     dcnt,
    output logic [CW-1:0]     ptr,
    output logic [WW-1:0]     rd_data
);
    logic [SW-1:0] sel;
    logic          avail;

    // Channel number of the ptr-th enabled channel
    always_comb begin
        logic [CW-1:0] seen;
        seen = '0;
        sel  = '0;
        for (int i = 0; i < NCH; i++) begin
            if (cap_mask[i]) begin
                if (seen == ptr) sel = SW'(i);
                seen = seen + 1'b1;
            end
        end
    end

    assign avail   = (ptr < dcnt);
    assign rd_data = avail ? WW'(fill_word(snap[sel*DW +: DW])) : '1;

    always_ff @(posedge clk) begin
        if (rst)                 ptr <= '0;
        else if (start)          ptr <= '0;
        else if (rd_en && avail) ptr <= ptr + 1'b1;
    end
endmodule

// File: rtl/cvs_slice.sv
module cvs_slice
    import cvs_pkg::*;
#(
    parameter int unsigned NCH       = CVS_NCH,
    parameter int unsigned DW        = CVS_DW,
    parameter int unsigned WW        = CVS_WW,
    parameter int unsigned FIRST_LAT = 4,
    parameter int unsigned SLOT_LAT  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [WW-1:0]     cfg_wdata,
    input  logic              start,
    input  logic              rd_en,
    input  logic [NCH*DW-1:0] smp_in,
    output logic [WW-1:0]     rd_data,
    output logic              first_rdy,
    output logic              last_rdy
);
    localparam int unsigned CW = $clog2(NCH + 1);

    logic [NCH-1:0]    mask_q;
    logic [NCH-1:0]    cap_mask;
    logic [NCH*DW-1:0] snap;
    logic [CW-1:0]     n_en;
    logic [CW-1:0]     dcnt;
    logic [CW-1:0]     ptr;

    cvs_capture #(.NCH(NCH), .DW(DW)) u_cap (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mask(cfg_wdata[NCH-1:0]),
        .start(start), .smp_in(smp_in), .mask_q(mask_q), .cap_mask(cap_mask),
        .snap(snap), .n_en(n_en)
    );

    cvs_pacer #(.CW(CW), .FIRST_LAT(FIRST_LAT), .SLOT_LAT(SLOT_LAT)) u_pace (
        .clk(clk), .rst(rst), .start(start), .mask_nz(|mask_q), .n_en(n_en),
        .dcnt(dcnt), .first_q(first_rdy), .last_q(last_rdy)
    );

    cvs_reader #(.NCH(NCH), .DW(DW), .WW(WW)) u_rd (
        .clk(clk), .rst(rst), .start(start), .rd_en(rd_en), .cap_mask(cap_mask),
        .snap(snap), .dcnt(dcnt), .ptr(ptr), .rd_data(rd_data)
    );
endmodule

// File: rtl/cvs_slice_chk.sv
module cvs_slice_chk #(
    parameter int unsigned NCH = 8,
    parameter int unsigned DW  = 12,
    parameter int unsigned WW  = 16,
    parameter int unsigned CW  = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           cfg_we,
    input logic [WW-1:0]  cfg_wdata,
    input logic           start,
    input logic [NCH-1:0] mask_q,
    input logic [CW-1:0]  n_en,
    input logic [CW-1:0]  dcnt,
    input logic [CW-1:0]  ptr,
    input logic [WW-1:0]  rd_data,
    input logic           first_rdy,
    input logic           last_rdy
);
    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> mask_q == $past(cfg_wdata[NCH-1:0])); // R1
    AST_PAD_ONES: assert property (@(posedge clk) disable iff (rst)
        &rd_data[WW-1:DW]); // R5
    AST_LAST_AFTER_FIRST: assert property (@(posedge clk) disable iff (rst)
        last_rdy |-> first_rdy); // R6
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (first_rdy && !start) |=> first_rdy); // R6
    AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (start && mask_q != '0) |=> (!first_rdy && !last_rdy && ptr == '0)); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (ptr <= dcnt) && (dcnt <= n_en)); // R9
    AST_EMPTY_RUN: assert property (@(posedge clk) disable iff (rst)
        (start && mask_q == '0) |=> (first_rdy && last_rdy)); // R10
endmodule

bind cvs_slice cvs_slice_chk #(.NCH(NCH), .DW(DW), .WW(WW), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .start(start),
    .mask_q(mask_q), .n_en(n_en), .dcnt(dcnt), .ptr(ptr), .rd_data(rd_data),
    .first_rdy(first_rdy), .last_rdy(last_rdy)
);

// File: tb/sim_cvs_slice.sv
module sim_cvs_slice;
    localparam int NCH = 8;
    localparam int DW  = 12;
    localparam int WW  = 16;
    localparam int FL  = 4;
    localparam int SL  = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [WW-1:0]     cfg_wdata = '0;
    logic              start = 1'b0;
    logic              rd_en = 1'b0;
    logic [NCH*DW-1:0] smp_in = '0;
    logic [WW-1:0]     rd_data;
    logic              first_rdy, last_rdy;

    always #10 clk = ~clk;

    cvs_slice #(.FIRST_LAT(FL), .SLOT_LAT(SL)) u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .start(start), .rd_en(rd_en), .smp_in(smp_in),
        .rd_data(rd_data), .first_rdy(first_rdy), .last_rdy(last_rdy)
    );

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R2";
    bit    done_flag = 0;

    // Behavioural reference
    logic [7:0] m_mask;
    int         m_q[$];
    bit         m_started;
    int         m_age, m_ridx;

    function automatic int done_of(int a);
        int d;
        if (!m_started || m_q.size() == 0 || a < FL) return 0;
        d = 1 + (a - FL) / SL;
        return (d > m_q.size()) ? m_q.size() : d;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        int dpre, d, ed;
        dpre = done_of(m_age);
        if (rst) begin
            m_mask = 8'hFF; m_started = 0; m_q.delete(); m_age = 0; m_ridx = 0;
        end else begin
            if (start) begin
                m_q.delete();
                for (int i = 0; i < NCH; i++)
                    if (m_mask[i]) m_q.push_back(int'(smp_in[i*DW +: DW]));
                m_started = 1; m_age = 0; m_ridx = 0;
            end else begin
                if (rd_en && m_ridx < dpre) m_ridx++;
                if (m_started) m_age++;
            end
            if (cfg_we) m_mask = cfg_wdata[7:0];
        end
        #5;
        d  = done_of(m_age);
        ed = (m_ridx < d) ? (32'hF000 | m_q[m_ridx]) : 32'hFFFF;
        chk(cur_req, "rd_data", int'(rd_data), ed);
        chk(cur_req, "first_rdy", int'(first_rdy),
            int'(m_started && (m_q.size() == 0 || d >= 1)));
        chk(cur_req, "last_rdy", int'(last_rdy), int'(m_started && d == m_q.size()));
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic cfg(logic [15:0] v);
        @(negedge clk); cfg_we = 1; cfg_wdata = v;
        @(negedge clk); cfg_we = 0;
    endtask
    task automatic go();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
    endtask
    task automatic rd(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); rd_en = 1;
            @(negedge clk); rd_en = 0;
        end
    endtask
    task automatic samples(int base);
        for (int i = 0; i < NCH; i++) smp_in[i*DW +: DW] = DW'(base + i * 'h135);
    endtask

    initial begin
        samples('h0A1);
        tick(3);
        chk("R2", "reset rd_data", int'(rd_data), 'hFFFF);
        chk("R2", "reset flags", int'({first_rdy, last_rdy}), 0);
        @(negedge clk); rst = 0;
        tick(2);
        // R2 default mask and R4 order, R5 format, R6 timing
        cur_req = "R4"; go(); samples('h777);   // R3: later input change
        tick(FL + 7 * SL + 2); rd(9);           // ninth read R9
        // R1 upper bits ignored, reads before ready (R9)
        cur_req = "R1"; cfg(16'hA521); samples('h100); go(); rd(2); tick(10); rd(3);
        // R7 shorter sequence with fewer channels
        cur_req = "R7"; cfg(16'h0080); go(); tick(FL + 2); rd(2);
        cfg(16'h0081); go(); tick(FL + SL + 1); rd(3);
        // R10 empty mask
        cur_req = "R10"; cfg(16'hFF00); go(); tick(3); rd(2);
        // R8 restart in the middle of a readout
        cur_req = "R8"; cfg(16'h00FF); samples('h222); go(); tick(FL + 3 * SL); rd(3);
        samples('h555); go(); tick(2); rd(1); tick(FL + 8 * SL); rd(9);
        // R11 mask written during a run, R3 inputs changed during a run
        cur_req = "R11"; cfg(16'h0066); go(); cfg(16'h0011); samples('h999);
        tick(FL + 4 * SL); rd(5); go(); tick(FL + 2 * SL); rd(3);
        // R6 mixed patterns with interleaved reads
        cur_req = "R6";
        for (int k = 0; k < 24; k++) begin
            samples(int'($urandom & 'hFFF));
            cfg(16'($urandom));
            go();
            for (int j = 0; j < 20; j++) begin
                @(negedge clk); rd_en = $urandom_range(0, 2) == 0;
            end
            @(negedge clk); rd_en = 0;
            rd(4);
        end
        tick(3);
        done_flag = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule